// File: doc/BRIEF.md
# Buffered Auto-Repeat Serial Transmitter

This block sends a block of bytes from its own 32-byte buffer RAM as a serial clock and data pair, with no help from software between bytes. Software fills the buffer through a CPU port, sets the block length, the half-period of the serial clock and the idle gap between bytes, and then pulses a start input. A transfer address counter steps through the buffer. The byte for each address is fetched from the RAM during the gap that precedes it.

In basic mode the block sends its bytes once and then pulses a completion interrupt. In repeat mode the address counter wraps to zero after the last byte, no interrupt is raised, and the block sends the buffer again until software clears an enable. The CPU always wins a collision on the buffer RAM. The transmitter then retries its fetch every cycle, and its gap counter waits until the fetch is granted, so the gap grows by one cycle for each blocked cycle. Two optional handshakes can be switched on: a busy input that holds off the next byte, and a one-cycle strobe output after each byte.

The controller has four named states. `ST_IDLE` waits for a qualified start. `ST_GAP` fetches the next byte and counts the gap. `ST_SHIFT` waits while the bit shifter sends the byte. `ST_DONE` drives the one-cycle interrupt. The transitions are:
- IDLE→GAP on a qualified start.
- GAP→SHIFT when the byte is held, the gap has expired and no busy hold applies.
- GAP→IDLE when an enable is lost.
- SHIFT→GAP when the byte ends and the block goes on, either at the next address or wrapped to zero in repeat mode.
- SHIFT→DONE when the last byte ends in basic mode.
- SHIFT→IDLE when the byte ends with an enable lost.
- DONE→IDLE always.

Top module: `auto_serial_tx`

## Requirements
- R1: A transfer starts only when `start_i` is 1 while `cfg_if_en`, `cfg_auto_en`, `cfg_auto_mode` and `cfg_tx_en` are all 1. Otherwise the block stays idle: `active_o`=0 and `sclk_o` stays high.
- R2: `sclk_o` idles high. Each byte is sent MSB first. `sdo_o` changes only when `sclk_o` falls. Each low and high half of a bit lasts `cfg_clkdiv` clocks, and a value of 0 counts as 1.
- R3: One block is the bytes at buffer addresses 0 to N-1, where N = `cfg_count`, and a `cfg_count` of 0 means 32.
- R4: In basic mode (`cfg_repeat`=0), `done_irq_o` is high for exactly one clock after the last byte of the block, and the block then goes idle.
- R5: In repeat mode (`cfg_repeat`=1), the address wraps to 0 after byte N-1 with the same gap as any other byte, and `done_irq_o` stays 0.
- R6: With no contention and no busy hold, `sclk_o` stays high for exactly `cfg_clkdiv`+`cfg_interval`+4 clocks between the last rising edge of one byte and the first falling edge of the next.
- R7: The CPU has priority on the buffer RAM. Each cycle in which `cpu_req_i` blocks the transmitter's fetch lengthens that gap by one clock. While the first fetch is blocked, no byte starts.
- R8: With `cfg_strobe_en`=1, `strobe_o` pulses high for exactly one clock after each byte. With `cfg_strobe_en`=0 it stays 0.
- R9: With `cfg_busy_en`=1, no byte starts while `busy_i` is 1.
- R10: Clearing `cfg_if_en` or `cfg_auto_en` stops the transfer at the end of the current byte and resets the address to 0, so the next start begins at address 0.
- R11: A CPU write (`cpu_req_i`=1, `cpu_we_i`=1) stores `cpu_wdata_i` at `cpu_addr_i`. A CPU read (`cpu_req_i`=1, `cpu_we_i`=0) returns that byte on `cpu_rdata_o` one clock later, also while a transfer is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_if_en | input | 1 | Interface enable |
| cfg_auto_en | input | 1 | Automatic transfer enable |
| cfg_auto_mode | input | 1 | Automatic mode select |
| cfg_tx_en | input | 1 | Transmit enable |
| cfg_repeat | input | 1 | 1 = repeat mode, 0 = basic mode |
| cfg_busy_en | input | 1 | Busy hold-off enable |
| cfg_strobe_en | input | 1 | Strobe pulse enable |
| cfg_count | input | 5 | Block length in bytes, 0 = 32 |
| cfg_interval | input | 8 | Gap count between bytes |
| cfg_clkdiv | input | 8 | Half-bit length in clocks, 0 = 1 |
| start_i | input | 1 | Start trigger |
| busy_i | input | 1 | Busy input from the receiver |
| cpu_req_i | input | 1 | CPU buffer access request |
| cpu_we_i | input | 1 | CPU write select |
| cpu_addr_i | input | 5 | CPU buffer address |
| cpu_wdata_i | input | 8 | CPU write data |
| cpu_rdata_o | output | 8 | CPU read data, one clock after the request |
| sclk_o | output | 1 | Serial clock, idles high |
| sdo_o | output | 1 | Serial data out |
| strobe_o | output | 1 | One-clock strobe after each byte |
| done_irq_o | output | 1 | Block-complete interrupt pulse |
| active_o | output | 1 | Transfer in progress |

## Verification
CPU read data is due one clock after the request. It is checked at the next falling clock edge. Gap lengths follow a fixed count: `cfg_clkdiv` high clocks, one clock for the end of the byte, two clocks for the fetch, one clock in which the fetched byte is first held, and `cfg_interval` counted clocks. The monitor measures each high and low stretch of `sclk_o` in falling-edge samples and compares it with that count, plus one clock for each cycle in which the bench holds `cpu_req_i` during the fetch. Serial bytes are rebuilt at each rising edge of `sclk_o` and checked against a queue filled by the driver. Interrupt and strobe pulses are counted, and their widths are checked over whole runs.

// File: rtl/ast_pkg.sv
package ast_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_GAP   = 2'd1,
        ST_SHIFT = 2'd2,
        ST_DONE  = 2'd3
    } ast_state_t;

endpackage

// File: rtl/ast_bufram.sv
module ast_bufram #(
    parameter int DEPTH = 32,
    parameter int DW    = 8,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_req_i,
    input  logic          cpu_we_i,
    input  logic [AW-1:0] cpu_addr_i,
    input  logic [DW-1:0] cpu_wdata_i,
    output logic [DW-1:0] cpu_rdata_o,
    input  logic          tx_rd_en_i,
    input  logic [AW-1:0] tx_addr_i,
    output logic          tx_gnt_o,
    output logic [DW-1:0] tx_q_o
);

    logic [DW-1:0] mem [DEPTH];

    // CPU side always wins; the transmitter only gets an idle port
    assign tx_gnt_o = tx_rd_en_i && !cpu_req_i;

    always_ff @(posedge clk) begin
        if (cpu_req_i && cpu_we_i) begin
            mem[cpu_addr_i] <= cpu_wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cpu_rdata_o <= '0;
            tx_q_o      <= '0;
        end else begin
            if (cpu_req_i && !cpu_we_i) begin
                cpu_rdata_o <= mem[cpu_addr_i];
            end
            if (tx_gnt_o) begin
                tx_q_o <= mem[tx_addr_i];
            end
        end
    end

    // R11: a CPU write lands in the addressed word
    p_write_lands_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req_i && cpu_we_i) |=> (mem[$past(cpu_addr_i)] == $past(cpu_wdata_i)));

endmodule

// File: rtl/ast_shifter.sv
module ast_shifter #(
    parameter int DW = 8,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [DW-1:0] data_i,
    input  logic [CW-1:0] div_i,
    output logic          sclk_o,
    output logic          sdo_o,
    output logic          done_o
);

    localparam int BW = (DW > 1) ? $clog2(DW) : 1;

    logic [DW-1:0] sh_q;
    logic [BW-1:0] bit_q;
    logic [CW-1:0] cnt_q;
    logic          phase_q;
    logic          run_q;
    logic [CW-1:0] half_m1;

    assign half_m1 = (div_i == '0) ? '0 : div_i - 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q    <= '0;
            bit_q   <= '0;
            cnt_q   <= '0;
            phase_q <= 1'b0;
            run_q   <= 1'b0;
            sclk_o  <= 1'b1;
            sdo_o   <= 1'b1;
            done_o  <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (load_i) begin
                sh_q    <= data_i;
                sdo_o   <= data_i[DW-1];
                sclk_o  <= 1'b0;
                run_q   <= 1'b1;
                bit_q   <= '0;
                phase_q <= 1'b0;
                cnt_q   <= '0;
            end else if (run_q) begin
                if (cnt_q != half_m1) begin
                    cnt_q <= cnt_q + 1'b1;
                end else begin
                    cnt_q <= '0;
                    if (!phase_q) begin
                        sclk_o  <= 1'b1;
                        phase_q <= 1'b1;
                    end else if (bit_q == BW'(DW - 1)) begin
                        run_q  <= 1'b0;
                        done_o <= 1'b1;
                    end else begin
                        bit_q   <= bit_q + 1'b1;
                        sh_q    <= sh_q << 1;
                        sdo_o   <= sh_q[DW-2];
                        sclk_o  <= 1'b0;
                        phase_q <= 1'b0;
                    end
                end
            end
        end
    end

    // R2: data never moves while the serial clock rises
    p_sdo_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_o) |-> $stable(sdo_o));

    // R2: the clock is high whenever no byte is in flight
    p_idle_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !load_i) |=> sclk_o);

endmodule

// File: rtl/ast_ctrl.sv
module ast_ctrl
    import ast_pkg::*;
#(
    parameter int AW = 5,
    parameter int IW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_if_en,
    input  logic          cfg_auto_en,
    input  logic          cfg_auto_mode,
    input  logic          cfg_tx_en,
    input  logic          cfg_repeat,
    input  logic          cfg_busy_en,
    input  logic          cfg_strobe_en,
    input  logic [AW-1:0] cfg_count,
    input  logic [IW-1:0] cfg_interval,
    input  logic          start_i,
    input  logic          busy_i,
    input  logic          cpu_req_i,
    input  logic          gnt_i,
    input  logic          sh_done_i,
    output logic          rd_en_o,
    output logic [AW-1:0] rd_addr_o,
    output logic          load_o,
    output logic          strobe_o,
    output logic          irq_o,
    output logic          active_o,
    output logic          gap_o
);

    ast_state_t state_q, state_d;

    logic [AW-1:0] addr_q;
    logic [IW-1:0] gcnt_q;
    logic          pend_q;
    logic          have_q;
    logic          first_q;
    logic          strobe_q;

    logic          enabled;
    logic          go;
    logic          last;
    logic          gap_ready;
    logic [AW-1:0] last_addr;

    assign enabled   = cfg_if_en && cfg_auto_en;
    assign go        = start_i && enabled && cfg_auto_mode && cfg_tx_en;
    assign last_addr = cfg_count - 1'b1;
    assign last      = (addr_q == last_addr);
    assign gap_ready = have_q && (first_q || (gcnt_q >= cfg_interval))
                       && !(cfg_busy_en && busy_i);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (go) state_d = ST_GAP;
            end
            ST_GAP: begin
                if (!enabled)      state_d = ST_IDLE;
                else if (gap_ready) state_d = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (sh_done_i) begin
                    if (!enabled)                state_d = ST_IDLE;
                    else if (last && !cfg_repeat) state_d = ST_DONE;
                    else                         state_d = ST_GAP;
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // address, fetch and gap bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q   <= '0;
            gcnt_q   <= '0;
            pend_q   <= 1'b0;
            have_q   <= 1'b0;
            first_q  <= 1'b0;
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= (state_q == ST_SHIFT) && sh_done_i && cfg_strobe_en;
            unique case (state_q)
                ST_IDLE: begin
                    if (go) begin
                        addr_q  <= '0;
                        first_q <= 1'b1;
                        have_q  <= 1'b0;
                        pend_q  <= 1'b0;
                        gcnt_q  <= '0;
                    end
                end
                ST_GAP: begin
                    if (!enabled) begin
                        addr_q <= '0;
                        have_q <= 1'b0;
                        pend_q <= 1'b0;
                    end else if (gap_ready) begin
                        have_q  <= 1'b0;
                        first_q <= 1'b0;
                        gcnt_q  <= '0;
                    end else begin
                        pend_q <= gnt_i;
                        if (pend_q) have_q <= 1'b1;
                        if (have_q && (gcnt_q != '1)) gcnt_q <= gcnt_q + 1'b1;
                    end
                end
                ST_SHIFT: begin
                    if (sh_done_i) begin
                        if (!enabled || last) addr_q <= '0;
                        else                  addr_q <= addr_q + 1'b1;
                        gcnt_q <= '0;
                        have_q <= 1'b0;
                        pend_q <= 1'b0;
                    end
                end
                ST_DONE: begin
                    addr_q <= '0;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        rd_addr_o = addr_q;
        rd_en_o   = (state_q == ST_GAP) && enabled && !have_q && !pend_q;
        load_o    = (state_q == ST_GAP) && enabled && gap_ready;
        irq_o     = (state_q == ST_DONE);
        active_o  = (state_q != ST_IDLE);
        gap_o     = (state_q == ST_GAP);
        strobe_o  = strobe_q;
    end

    // R4: the interrupt is a single-clock pulse
    p_irq_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    // R5: a byte ending in repeat mode never leads to the interrupt
    p_repeat_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_SHIFT) && sh_done_i && cfg_repeat) |=> !irq_o);

    // R3: bytes are taken only from addresses inside the block
    p_addr_in_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT) |-> ((cfg_count == '0) || (addr_q < cfg_count)));

    // R7: a fetch blocked by the CPU leaves nothing pending
    p_cpu_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_GAP) && enabled && !have_q && !pend_q && cpu_req_i)
        |=> !pend_q);

    // R8: the strobe lasts one clock
    p_strobe_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |=> !strobe_o);

endmodule

// File: rtl/auto_serial_tx.sv
module auto_serial_tx #(
    parameter  int DEPTH = 32,
    parameter  int DW    = 8,
    parameter  int IW    = 8,
    parameter  int CW    = 8,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_if_en,
    input  logic          cfg_auto_en,
    input  logic          cfg_auto_mode,
    input  logic          cfg_tx_en,
    input  logic          cfg_repeat,
    input  logic          cfg_busy_en,
    input  logic          cfg_strobe_en,
    input  logic [AW-1:0] cfg_count,
    input  logic [IW-1:0] cfg_interval,
    input  logic [CW-1:0] cfg_clkdiv,
    input  logic          start_i,
    input  logic          busy_i,
    input  logic          cpu_req_i,
    input  logic          cpu_we_i,
    input  logic [AW-1:0] cpu_addr_i,
    input  logic [DW-1:0] cpu_wdata_i,
    output logic [DW-1:0] cpu_rdata_o,
    output logic          sclk_o,
    output logic          sdo_o,
    output logic          strobe_o,
    output logic          done_irq_o,
    output logic          active_o
);

    logic          rd_en;
    logic [AW-1:0] rd_addr;
    logic          gnt;
    logic [DW-1:0] tx_q;
    logic          load;
    logic          sh_done;
    logic          in_gap;

    ast_bufram #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_ram (
        .clk         (clk),
        .rst_n       (rst_n),
        .cpu_req_i   (cpu_req_i),
        .cpu_we_i    (cpu_we_i),
        .cpu_addr_i  (cpu_addr_i),
        .cpu_wdata_i (cpu_wdata_i),
        .cpu_rdata_o (cpu_rdata_o),
        .tx_rd_en_i  (rd_en),
        .tx_addr_i   (rd_addr),
        .tx_gnt_o    (gnt),
        .tx_q_o      (tx_q)
    );

    ast_ctrl #(.AW(AW), .IW(IW)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_if_en     (cfg_if_en),
        .cfg_auto_en   (cfg_auto_en),
        .cfg_auto_mode (cfg_auto_mode),
        .cfg_tx_en     (cfg_tx_en),
        .cfg_repeat    (cfg_repeat),
        .cfg_busy_en   (cfg_busy_en),
        .cfg_strobe_en (cfg_strobe_en),
        .cfg_count     (cfg_count),
        .cfg_interval  (cfg_interval),
        .start_i       (start_i),
        .busy_i        (busy_i),
        .cpu_req_i     (cpu_req_i),
        .gnt_i         (gnt),
        .sh_done_i     (sh_done),
        .rd_en_o       (rd_en),
        .rd_addr_o     (rd_addr),
        .load_o        (load),
        .strobe_o      (strobe_o),
        .irq_o         (done_irq_o),
        .active_o      (active_o),
        .gap_o         (in_gap)
    );

    ast_shifter #(.DW(DW), .CW(CW)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .data_i (tx_q),
        .div_i  (cfg_clkdiv),
        .sclk_o (sclk_o),
        .sdo_o  (sdo_o),
        .done_o (sh_done)
    );

    // R9: a busy hold in the gap keeps the serial clock high
    p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_gap && cfg_busy_en && busy_i) |=> sclk_o);

    // R1: an idle block keeps the serial clock high
    p_idle_clock_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_o && $past(!active_o)) |-> sclk_o);

endmodule

// File: tb/auto_serial_tx_tb_top.sv
module auto_serial_tx_tb_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_if_en = 1'b1, cfg_auto_en = 1'b1, cfg_auto_mode = 1'b1, cfg_tx_en = 1'b1;
    logic       cfg_repeat = 1'b0, cfg_busy_en = 1'b0, cfg_strobe_en = 1'b0;
    logic [4:0] cfg_count = 5'd1;
    logic [7:0] cfg_interval = 8'd0, cfg_clkdiv = 8'd1;
    logic       start_i = 1'b0, busy_i = 1'b0;
    logic       cpu_req_i = 1'b0, cpu_we_i = 1'b0;
    logic [4:0] cpu_addr_i = '0;
    logic [7:0] cpu_wdata_i = '0;
    logic [7:0] cpu_rdata_o;
    logic       sclk_o, sdo_o, strobe_o, done_irq_o, active_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    auto_serial_tx dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_if_en(cfg_if_en), .cfg_auto_en(cfg_auto_en), .cfg_auto_mode(cfg_auto_mode),
        .cfg_tx_en(cfg_tx_en), .cfg_repeat(cfg_repeat), .cfg_busy_en(cfg_busy_en),
        .cfg_strobe_en(cfg_strobe_en), .cfg_count(cfg_count), .cfg_interval(cfg_interval),
        .cfg_clkdiv(cfg_clkdiv), .start_i(start_i), .busy_i(busy_i),
        .cpu_req_i(cpu_req_i), .cpu_we_i(cpu_we_i), .cpu_addr_i(cpu_addr_i),
        .cpu_wdata_i(cpu_wdata_i), .cpu_rdata_o(cpu_rdata_o),
        .sclk_o(sclk_o), .sdo_o(sdo_o), .strobe_o(strobe_o),
        .done_irq_o(done_irq_o), .active_o(active_o)
    );

    int   checks = 0, failures = 0;
    bit   reported = 1'b0;
    logic [7:0] exp_q[$];
    int   gap_q[$];
    int   exp_div = 1;
    int   rx_count = 0, fall_cnt = 0, strobe_cnt = 0, irq_cnt = 0;

    function automatic logic [7:0] pat(int i);
        return 8'((i * 53 + 17) ^ (i << 5));
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!reported) begin
            reported = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        end
    endtask

    // monitor: rebuilds bytes, measures clock stretches, counts pulses
    logic       prev_sclk = 1'b1, prev_strobe = 1'b0;
    int         highrun = 0, lowrun = 0, bitcnt = 0;
    logic [7:0] acc = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (sclk_o) highrun++; else lowrun++;
            if (prev_sclk && !sclk_o) begin
                fall_cnt++;
                if (bitcnt == 0) gap_q.push_back(highrun);
                else chk(highrun == exp_div, "R2 high half", highrun, exp_div);
                highrun = 0;
            end
            if (!prev_sclk && sclk_o) begin
                chk(lowrun == exp_div, "R2 low half", lowrun, exp_div);
                lowrun = 0;
                acc = {acc[6:0], sdo_o};
                bitcnt++;
                if (bitcnt == 8) begin
                    bitcnt = 0;
                    rx_count++;
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R3 unexpected byte", int'(acc), -1);
                    end else begin
                        logic [7:0] e;
                        e = exp_q.pop_front();
                        chk(acc == e, "R2/R3 byte", int'(acc), int'(e));
                    end
                end
            end
            if (strobe_o) begin
                strobe_cnt++;
                if (prev_strobe) chk(1'b0, "R8 strobe width", 2, 1);
            end
            if (done_irq_o) irq_cnt++;
            prev_sclk   = sclk_o;
            prev_strobe = strobe_o;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        summary();
        $finish;
    end

    task automatic cpu_wr(int a, logic [7:0] d);
        @(negedge clk);
        cpu_req_i = 1'b1; cpu_we_i = 1'b1; cpu_addr_i = 5'(a); cpu_wdata_i = d;
        @(negedge clk);
        cpu_req_i = 1'b0; cpu_we_i = 1'b0;
    endtask

    task automatic cpu_rd_chk(int a);
        @(negedge clk);
        cpu_req_i = 1'b1; cpu_we_i = 1'b0; cpu_addr_i = 5'(a);
        @(negedge clk);
        cpu_req_i = 1'b0;
        chk(cpu_rdata_o == pat(a), "R11 readback", int'(cpu_rdata_o), int'(pat(a)));
    endtask

    task automatic expect_block(int n);
        for (int i = 0; i < n; i++) exp_q.push_back(pat(i));
    endtask

    task automatic pulse_start();
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
    endtask

    task automatic wait_idle();
        int n;
        n = 0;
        repeat (3) @(negedge clk);
        while (active_o && n < 20000) begin @(negedge clk); n++; end
        repeat (3) @(negedge clk);
    endtask

    initial begin
        int f0, r0, i0, s0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk(sclk_o == 1'b1, "R2 reset sclk", sclk_o, 1);
        chk(active_o == 1'b0, "R1 reset active", active_o, 0);
        chk(done_irq_o == 1'b0, "R4 reset irq", done_irq_o, 0);
        chk(strobe_o == 1'b0, "R8 reset strobe", strobe_o, 0);

        // R11 fill and read back
        for (int a = 0; a < 32; a++) cpu_wr(a, pat(a));
        cpu_rd_chk(0); cpu_rd_chk(17); cpu_rd_chk(31);

        // R1 no start without all qualifiers
        f0 = fall_cnt;
        cfg_tx_en = 1'b0; pulse_start(); repeat (30) @(negedge clk);
        chk(active_o == 0 && fall_cnt == f0, "R1 tx_en low", fall_cnt - f0, 0);
        cfg_tx_en = 1'b1; cfg_auto_mode = 1'b0; pulse_start(); repeat (30) @(negedge clk);
        chk(active_o == 0 && fall_cnt == f0, "R1 auto_mode low", fall_cnt - f0, 0);
        cfg_auto_mode = 1'b1;

        // R3 R4 R6 basic block of 3, div 2, interval 3
        cfg_count = 5'd3; cfg_clkdiv = 8'd2; cfg_interval = 8'd3; exp_div = 2;
        gap_q.delete(); r0 = rx_count; i0 = irq_cnt;
        expect_block(3); pulse_start(); wait_idle();
        chk(rx_count - r0 == 3, "R3 block of 3", rx_count - r0, 3);
        chk(irq_cnt - i0 == 1, "R4 one irq pulse", irq_cnt - i0, 1);
        chk(gap_q.size() == 3 && gap_q[1] == 9, "R6 gap 1", gap_q.size() > 1 ? gap_q[1] : -1, 9);
        chk(gap_q.size() == 3 && gap_q[2] == 9, "R6 gap 2", gap_q.size() > 2 ? gap_q[2] : -1, 9);

        // R3 count 0 means 32, div 0 counts as 1, interval 0
        cfg_count = 5'd0; cfg_clkdiv = 8'd0; cfg_interval = 8'd0; exp_div = 1;
        gap_q.delete(); r0 = rx_count; i0 = irq_cnt;
        expect_block(32); pulse_start(); wait_idle();
        chk(rx_count - r0 == 32, "R3 count zero is 32", rx_count - r0, 32);
        chk(irq_cnt - i0 == 1, "R4 irq after 32", irq_cnt - i0, 1);
        chk(gap_q.size() == 32 && gap_q[31] == 5, "R6 gap div1 int0", gap_q.size() == 32 ? gap_q[31] : -1, 5);

        // R5 R8 R10 repeat mode with strobe, stopped by auto enable
        cfg_repeat = 1'b1; cfg_strobe_en = 1'b1; cfg_count = 5'd2;
        cfg_clkdiv = 8'd3; cfg_interval = 8'd1; exp_div = 3;
        gap_q.delete(); r0 = rx_count; i0 = irq_cnt; s0 = strobe_cnt;
        for (int k = 0; k < 5; k++) exp_q.push_back(pat(k % 2));
        pulse_start();
        wait (rx_count == r0 + 5);
        cfg_auto_en = 1'b0;
        repeat (80) @(negedge clk);
        chk(active_o == 0 && rx_count - r0 == 5, "R10 stop at byte end", rx_count - r0, 5);
        chk(irq_cnt == i0, "R5 no irq in repeat", irq_cnt - i0, 0);
        chk(strobe_cnt - s0 == 5, "R8 strobe per byte", strobe_cnt - s0, 5);
        chk(gap_q.size() >= 3 && gap_q[2] == 8, "R5 wrap gap", gap_q.size() >= 3 ? gap_q[2] : -1, 8);
        cfg_auto_en = 1'b1; cfg_repeat = 1'b0; cfg_strobe_en = 1'b0; cfg_count = 5'd1;
        r0 = rx_count; s0 = strobe_cnt;
        expect_block(1); pulse_start(); wait_idle();
        chk(rx_count - r0 == 1 && exp_q.size() == 0, "R10 restart at address 0", exp_q.size(), 0);
        chk(strobe_cnt == s0, "R8 strobe off", strobe_cnt - s0, 0);

        // R7 contention: blocked first fetch, then a stretched gap
        cfg_count = 5'd2; cfg_clkdiv = 8'd1; cfg_interval = 8'd2; exp_div = 1;
        gap_q.delete(); r0 = rx_count; f0 = fall_cnt;
        expect_block(2);
        @(negedge clk); cpu_req_i = 1'b1; cpu_we_i = 1'b0; cpu_addr_i = 5'd5;
        pulse_start();
        repeat (20) @(negedge clk);
        chk(fall_cnt == f0, "R7 blocked first fetch", fall_cnt - f0, 0);
        cpu_req_i = 1'b0;
        wait (rx_count == r0 + 1);
        cpu_req_i = 1'b1; cpu_addr_i = 5'd9;
        @(negedge clk);
        chk(cpu_rdata_o == pat(9), "R11 read during transfer", int'(cpu_rdata_o), int'(pat(9)));
        repeat (6) @(negedge clk);
        cpu_req_i = 1'b0;
        wait_idle();
        chk(gap_q.size() == 2 && gap_q[1] == 12, "R7 gap stretch", gap_q.size() == 2 ? gap_q[1] : -1, 12);

        // R9 busy hold
        cfg_busy_en = 1'b1; busy_i = 1'b1; cfg_count = 5'd1;
        f0 = fall_cnt; r0 = rx_count;
        expect_block(1); pulse_start();
        repeat (40) @(negedge clk);
        chk(fall_cnt == f0 && active_o, "R9 busy holds byte", fall_cnt - f0, 0);
        busy_i = 1'b0;
        wait_idle();
        chk(rx_count - r0 == 1 && exp_q.size() == 0, "R9 byte after release", rx_count - r0, 1);
        cfg_busy_en = 1'b0;

        summary();
        $finish;
    end

endmodule